// File: doc/BRIEF.md
# Complementary Gate Driver with Dead-Time Control

This block turns one raw PWM waveform, such as the output of a duty-cycle comparator, into a high-side and low-side gate pair for a half bridge. A programmable count of clock cycles sets the dead time. A two-bit mode field chooses how that count is applied. It can keep both switches off around every transition. It can make the two conducting intervals overlap. It can ignore the count entirely. It can also shift both edges in one direction to compensate for the load current. In that last case, a current-direction input and a polarity bit select which gate loses time and which gains it.

The mode field and the dead-time count are configuration. They are captured only while the generator is disabled, so a change while it runs has no effect. The polarity bit and the current-direction input are sampled every cycle. The raw PWM is registered once on entry and the gates are registered once on exit. Every output therefore follows its input two clock edges later, plus any dead-time shift.

Top module: `pwm_deadband`

## Requirements
- R1: With mode 2'b00 and dead count D, a gate turns on only after its own drive level has been present for more than D consecutive samples. The high gate follows the raw PWM high and the low gate follows the raw PWM low. Both gates turn off two edges after their level ends, so the two gates are never on together.
- R2: With mode 2'b01, each gate turns on two edges after its level starts. Each gate stays on for D extra cycles after its level ends, so the two gates overlap by D cycles at every transition and are never both off while enabled.
- R3: With mode 2'b10, the high gate equals the raw PWM delayed by two edges and the low gate is its exact inverse while enabled.
- R4: With mode 2'b11, the high side is shortened when polarity and direction are equal (1/1 or 0/0); otherwise the low side is shortened. The shortened gate rises D cycles late. The other gate falls D cycles late at that same instant, so the pair stays complementary.
- R5: The polarity bit and the direction input have no effect on the outputs in modes 2'b00, 2'b01 and 2'b10.
- R6: Mode and dead count are captured on each clock edge where enable is low. Changes to them while enable is high have no effect on the outputs.
- R7: In mode 2'b00, a raw high or low pulse of D samples or fewer produces no pulse on the gate it would drive. No inverted or partial pulse appears on either gate.
- R8: Both gates are low during reset and two edges after enable is sampled low. Internal counters restart from zero.
- R9: With D = 0 in mode 2'b00, the high gate reproduces the raw PWM with a latency of exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable; configuration is captured while low |
| pwm_in | input | 1 | Raw PWM from the duty comparator |
| dead_cnt | input | DT_W | Dead time in clock cycles |
| mode_sel | input | 2 | 00 positive, 01 negative, 10 off, 11 compensation |
| comp_pol | input | 1 | Compensation polarity |
| comp_dir | input | 1 | Load current direction for compensation |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
A run counter that fails to clear shows up as a gate that switches on too early after a short opposite pulse. The error is visible at the first rising edge that follows it, at most D+2 cycles after the fault. A stale captured mode or count changes the edge positions on the very next transition. A wrong steering decision in compensation mode flips which gate moves within two edges of the direction input changing. Every gate value is compared on every cycle against an independent run-length model, so any such error surfaces within one PWM period.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

  typedef enum logic [1:0] {
    DB_POS  = 2'b00,
    DB_NEG  = 2'b01,
    DB_OFF  = 2'b10,
    DB_COMP = 2'b11
  } db_mode_e;

  // High side loses time when polarity and direction agree.
  function automatic logic shorten_high(input logic pol, input logic dir);
    return ~(pol ^ dir);
  endfunction

  // Run counter step: clear on inactive level, saturate at the limit.
  function automatic logic [15:0] run_step(input logic [15:0] cnt,
                                           input logic [15:0] lim,
                                           input logic        lvl);
    if (!lvl)            return '0;
    else if (cnt < lim)  return cnt + 16'd1;
    else                 return cnt;
  endfunction

endpackage

// File: rtl/pwm_db_cfg.sv
module pwm_db_cfg
  import pwm_db_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            pwm_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic [1:0]      mode_i,
  input  logic            pol_i,
  input  logic            dir_i,
  output logic            en_q,
  output logic            pwm_q,
  output logic            pol_q,
  output logic            dir_q,
  output db_mode_e        mode_q,
  output logic [DT_W-1:0] dead_q
);

  logic cfg_load;
  assign cfg_load = ~en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pwm_q  <= 1'b0;
      pol_q  <= 1'b0;
      dir_q  <= 1'b0;
      mode_q <= DB_POS;
      dead_q <= '0;
    end else begin
      en_q  <= en_i;
      pwm_q <= pwm_i;
      pol_q <= pol_i;
      dir_q <= dir_i;
      if (cfg_load) begin
        mode_q <= db_mode_e'(mode_i);
        dead_q <= dead_i;
      end
    end
  end

  // R6: configuration only moves after an edge where enable was low
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) |-> ($stable(mode_q) && $stable(dead_q)));

endmodule

// File: rtl/pwm_db_run.sv
module pwm_db_run
  import pwm_db_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lvl_i,
  input  logic [DT_W-1:0] lim_i,
  output logic            run_o
);

  localparam int CW = 16;

  logic [DT_W-1:0] cnt_q;
  logic [CW-1:0]   cnt_ext;
  logic [CW-1:0]   lim_ext;
  logic [CW-1:0]   cnt_nxt;
  logic            reached;

  assign cnt_ext = CW'(cnt_q);
  assign lim_ext = CW'(lim_i);
  assign cnt_nxt = run_step(cnt_ext, lim_ext, lvl_i);
  assign reached = (cnt_q >= lim_i);
  assign run_o   = lvl_i & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt[DT_W-1:0];
  end

  // R7: an interrupted level always restarts the count from zero
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_i |=> (cnt_q == '0));

  // R1: a counter never grows while its level is absent
  a_r1_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(lvl_i));

endmodule

// File: rtl/pwm_db_steer.sv
module pwm_db_steer
  import pwm_db_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_q,
  input  logic     pwm_q,
  input  db_mode_e mode_q,
  input  logic     pol_q,
  input  logic     dir_q,
  input  logic     run_hi,
  input  logic     run_lo,
  output logic     gate_hi,
  output logic     gate_lo
);

  logic hi_nxt, lo_nxt;
  logic short_hi;

  assign short_hi = shorten_high(pol_q, dir_q);

  always_comb begin
    hi_nxt = 1'b0;
    lo_nxt = 1'b0;
    if (en_q) begin
      unique case (mode_q)
        DB_POS: begin
          hi_nxt = run_hi;
          lo_nxt = run_lo;
        end
        DB_NEG: begin
          hi_nxt = ~run_lo;
          lo_nxt = ~run_hi;
        end
        DB_OFF: begin
          hi_nxt = pwm_q;
          lo_nxt = ~pwm_q;
        end
        DB_COMP: begin
          if (short_hi) begin
            hi_nxt = run_hi;
            lo_nxt = ~run_hi;
          end else begin
            hi_nxt = ~run_lo;
            lo_nxt = run_lo;
          end
        end
        default: begin
          hi_nxt = 1'b0;
          lo_nxt = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= hi_nxt;
      gate_lo <= lo_nxt;
    end
  end

  // R4: compensation keeps the pair complementary
  a_r4_comp_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && $past(mode_q) == DB_COMP) |-> (gate_hi != gate_lo));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_db_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] dead_cnt,
  input  logic [1:0]      mode_sel,
  input  logic            comp_pol,
  input  logic            comp_dir,
  output logic            gate_hi,
  output logic            gate_lo
);

  localparam int NSIDE = 2;

  logic            en_q, pwm_q, pol_q, dir_q;
  db_mode_e        mode_q;
  logic [DT_W-1:0] dead_q;
  logic [NSIDE-1:0] lvl_vec;
  logic [NSIDE-1:0] run_vec;

  pwm_db_cfg #(.DT_W(DT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pwm_i(pwm_in),
    .dead_i(dead_cnt), .mode_i(mode_sel), .pol_i(comp_pol), .dir_i(comp_dir),
    .en_q(en_q), .pwm_q(pwm_q), .pol_q(pol_q), .dir_q(dir_q),
    .mode_q(mode_q), .dead_q(dead_q)
  );

  // index 0: high-side level, index 1: low-side level
  assign lvl_vec[0] = en_q & pwm_q;
  assign lvl_vec[1] = en_q & ~pwm_q;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    pwm_db_run #(.DT_W(DT_W)) u_run (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_vec[s]),
      .lim_i(dead_q), .run_o(run_vec[s])
    );
  end

  pwm_db_steer u_steer (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .pwm_q(pwm_q), .mode_q(mode_q),
    .pol_q(pol_q), .dir_q(dir_q), .run_hi(run_vec[0]), .run_lo(run_vec[1]),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // R1: positive dead time never lets both gates conduct
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == DB_POS) |-> !(gate_hi && gate_lo));

  // R2: negative dead time never leaves both gates off while running
  a_r2_never_both_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && $past(mode_q) == DB_NEG) |-> (gate_hi || gate_lo));

  // R3: disabled dead time gives an exact complement
  a_r3_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && $past(mode_q) == DB_OFF) |-> (gate_lo == !gate_hi));

  // R8: a disabled generator parks both gates low
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!gate_hi && !gate_lo));

endmodule

// File: tb/pwm_deadband_tb.sv
module pwm_deadband_tb;

  localparam int DT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic pwm_in = 1'b0;
  logic [DT_W-1:0] dead_cnt = '0;
  logic [1:0] mode_sel = 2'b00;
  logic comp_pol = 1'b0;
  logic comp_dir = 1'b0;
  logic gate_hi, gate_lo;

  always #4 clk = ~clk;

  pwm_deadband #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm_in), .dead_cnt(dead_cnt),
    .mode_sel(mode_sel), .comp_pol(comp_pol), .comp_dir(comp_dir),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "";

  // reference model state
  int m_ones = 0, m_zeros = 0;
  int m_d = 0;
  logic [1:0] m_mode = 2'b00;
  logic [1:0] m_pend = 2'b00;   // {hi, lo} expected after the next edge

  // Expected {hi,lo} from run-length flags, restated per mode.
  function automatic logic [1:0] ref_gates(logic [1:0] md, bit on, bit p,
                                           bit hi_ok, bit lo_ok, bit pol, bit dir);
    if (!on) return 2'b00;
    if (md == 2'b00) return {hi_ok, lo_ok};
    if (md == 2'b01) return {!lo_ok, !hi_ok};
    if (md == 2'b10) return {p, !p};
    if (pol == dir) return {hi_ok, !hi_ok};
    return {!lo_ok, lo_ok};
  endfunction

  function automatic string mode_tag(logic [1:0] md, bit on);
    if (!on) return "R8";
    case (md)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: hi/lo actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check((tag != "") ? tag : mode_tag(m_mode, en), {gate_hi, gate_lo}, m_pend);
    if (!en) begin
      m_mode = mode_sel;
      m_d = int'(dead_cnt);
      m_ones = 0;
      m_zeros = 0;
    end else if (pwm_in) begin
      m_ones++; m_zeros = 0;
    end else begin
      m_zeros++; m_ones = 0;
    end
    if (m_ones > 1000) m_ones = 1000;
    if (m_zeros > 1000) m_zeros = 1000;
    m_pend = ref_gates(m_mode, en, pwm_in, (m_ones > m_d), (m_zeros > m_d),
                       comp_pol, comp_dir);
  endtask

  task automatic configure(logic [1:0] md, int d);
    en = 1'b0;
    mode_sel = md;
    dead_cnt = DT_W'(d);
    step(); step();
    en = 1'b1;
  endtask

  task automatic level(bit v, int len);
    pwm_in = v;
    for (int i = 0; i < len; i++) step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", {gate_hi, gate_lo}, 2'b00);   // R8 reset state
    rst_n = 1'b1;

    // R9: zero dead time, two-edge latency
    tag = "R9";
    configure(2'b00, 0);
    level(1, 3); level(0, 2); level(1, 1); level(0, 4);

    // R7: pulses no longer than D vanish
    tag = "R7";
    configure(2'b00, 4);
    level(0, 6); level(1, 3); level(0, 6); level(1, 4); level(0, 2);
    level(1, 9); level(0, 4); level(1, 7);

    // R5: polarity/direction toggles have no effect outside compensation
    tag = "R5";
    for (int m = 0; m < 3; m++) begin
      configure(2'(m), 2);
      for (int i = 0; i < 30; i++) begin
        comp_pol = $urandom_range(0, 1);
        comp_dir = $urandom_range(0, 1);
        pwm_in = (i % 7) < 4;
        step();
      end
    end

    // R4: compensation, all four polarity/direction pairs
    tag = "R4";
    configure(2'b11, 3);
    for (int c = 0; c < 4; c++) begin
      comp_pol = c[1];
      comp_dir = c[0];
      level(0, 5); level(1, 6); level(0, 2); level(1, 2);
    end

    // R6: config changes while enabled are ignored
    tag = "R6";
    configure(2'b00, 3);
    for (int i = 0; i < 40; i++) begin
      mode_sel = 2'($urandom_range(0, 3));
      dead_cnt = DT_W'($urandom_range(0, 9));
      pwm_in = (i % 9) < 5;
      step();
    end

    // Random mix across all modes
    tag = "";
    for (int seg = 0; seg < 60; seg++) begin
      configure(2'($urandom_range(0, 3)), $urandom_range(0, 6));
      comp_pol = $urandom_range(0, 1);
      comp_dir = $urandom_range(0, 1);
      for (int k = 0; k < 12; k++) begin
        if ($urandom_range(0, 3) == 0) comp_dir = ~comp_dir;
        if ($urandom_range(0, 4) == 0) mode_sel = 2'($urandom_range(0, 3));
        level(bit'($urandom_range(0, 1)), $urandom_range(1, 10));
      end
    end

    // R8: disable parks both gates low
    tag = "R8";
    configure(2'b01, 2);
    level(1, 5);
    en = 1'b0;
    level(1, 4);
    level(0, 3);

    finish_run();
  end

endmodule